// File: doc/BRIEF.md
# Double-Buffered Sprite Attribute Store

This block keeps the per-sprite attribute table for a raster video pipeline in two copies. The processor side works only on a staging copy, which it may read and write at almost any time. The sprite renderer reads only an active copy. Once per frame, in the two scan lines that follow the last visible line, a copy engine moves the whole staging copy into the active copy. This means the renderer never sees a table that is only half updated while it is drawing.

The table holds a number of four-byte records. Within each record, byte offset 0 is the vertical position, offset 1 is the code/attribute byte, offset 2 is the horizontal position, and offset 3 is spare. The renderer reads one whole record per request, given by its record index. Processor accesses are refused during the copy window, and a busy flag reports that window. The raster counters come from outside. The horizontal counter advances once per pixel enable.

Top module: `spr_attr_dbuf`

## Requirements
- R1: Outside the copy window, a processor write with `cpu_we` stores `cpu_wdata` at byte address `cpu_addr` of the staging copy. A read with `cpu_re` returns the stored byte on `cpu_rdata` one clock later, and `cpu_rdata` holds that value until the next read.
- R2: Byte address bits [ADDR_W-1:2] select the record and bits [1:0] select the byte within it. On the renderer port, offset 0 appears on `rec_vpos`, offset 1 on `rec_code` and offset 2 on `rec_hpos`, one clock after `rec_idx` is presented. Offset 3 is never copied.
- R3: The copy window is the set of cycles in which `vcount` equals XFER_LINE or XFER_LINE+1. `xfer_busy` is high in exactly the cycles that follow a window cycle.
- R4: A processor write presented in a window cycle leaves the staging copy unchanged.
- R5: A processor read presented in a window cycle returns 8'hFF.
- R6: The copy starts from byte 0 after the first window cycle that has `hcount` equal to 0. It moves one byte, in ascending order, on each window cycle that has `pix_en` high, and stops after the last byte.
- R7: Outside the copy window, processor writes do not change what the renderer port returns.
- R8: A reset during the copy stops it. Bytes already moved keep their new value and the rest keep their old value. No copy happens until the window of a later frame, which then copies the whole table.
- R9: While `rst` is high, and in the cycle that follows it, `xfer_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; one copy step per enable |
| hcount | input | H_W | Horizontal raster position |
| vcount | input | V_W | Vertical raster line |
| cpu_addr | input | ADDR_W | Processor byte address into the staging copy |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_re | input | 1 | Processor read strobe |
| cpu_rdata | output | DATA_W | Processor read data, registered |
| xfer_busy | output | 1 | High during the copy window, one cycle delayed |
| rec_idx | input | IDX_W | Renderer record index |
| rec_vpos | output | DATA_W | Vertical position of the selected record |
| rec_code | output | DATA_W | Code/attribute byte of the selected record |
| rec_hpos | output | DATA_W | Horizontal position of the selected record |

## Verification
The bench builds the block with 8 records (32 bytes), 5-bit horizontal and 4-bit vertical counters, and a window on lines 7 and 8. It drives a 24-pixel by 10-line raster with a random pixel enable. A full frame is only a few hundred cycles long, so many copy windows fit in one run. A reset can be placed at a known byte count inside a copy, and random processor traffic reaches window edges, lane 3 writes and record reads right next to the window.

// File: rtl/spr_attr_pkg.sv
package spr_attr_pkg;

  // Copy engine states: HOLD waits for the raster to leave the window,
  // IDLE waits for the window start, COPY moves bytes.
  typedef enum logic [1:0] {
    XS_HOLD = 2'd0,
    XS_IDLE = 2'd1,
    XS_COPY = 2'd2
  } xfer_state_e;

  // Byte layout inside one four-byte record (the renderer depends on it)
  localparam int REC_BYTES = 4;
  localparam int OFS_VPOS  = 0;
  localparam int OFS_CODE  = 1;
  localparam int OFS_HPOS  = 2;
  localparam int USED_LANES = 3;

endpackage

// File: rtl/spr_stage_ram.sv
module spr_stage_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic              a_re,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port A: processor read/write, read-first
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_re) a_rdata <= mem[a_addr];
  end

  // Port B: copy engine read
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/spr_active_ram.sv
module spr_active_ram #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8,
  parameter int LANES  = 3
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [IDX_W+1:0]             waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [LANES-1:0][DATA_W-1:0] rd_rec
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] widx;
  logic [1:0]       wlane;

  assign widx  = waddr[IDX_W+1:2];
  assign wlane = waddr[1:0];

  // One narrow memory per used byte lane; writes to unused lanes drop out
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we && (wlane == 2'(l))) mem[widx] <= wdata;
      q <= mem[rd_idx];
    end

    assign rd_rec[l] = q;
  end
endmodule

// File: rtl/spr_xfer_ctrl.sv
module spr_xfer_ctrl
  import spr_attr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int H_W       = 10,
  parameter int V_W       = 10,
  parameter int XFER_LINE = 480
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [H_W-1:0]    hcount,
  input  logic [V_W-1:0]    vcount,
  output logic              in_win,
  output logic              busy,
  output logic              copying,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam logic [V_W-1:0]    WIN_FIRST = V_W'(XFER_LINE);
  localparam logic [V_W-1:0]    WIN_LAST  = V_W'(XFER_LINE + 1);
  localparam logic [ADDR_W-1:0] LAST_BYTE = '1;

  xfer_state_e       state;
  logic [ADDR_W-1:0] cnt;

  assign in_win  = (vcount == WIN_FIRST) || (vcount == WIN_LAST);
  assign copying = (state == XS_COPY);
  assign rd_en   = copying && in_win && pix_en;
  assign rd_addr = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= XS_HOLD;
      cnt     <= '0;
      busy    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      busy    <= in_win;
      wr_en   <= rd_en;
      wr_addr <= cnt;
      case (state)
        XS_HOLD: if (!in_win) state <= XS_IDLE;
        XS_IDLE: begin
          if (in_win && (hcount == '0)) begin
            state <= XS_COPY;
            cnt   <= '0;
          end
        end
        XS_COPY: begin
          if (!in_win) begin
            state <= XS_HOLD;
          end else if (pix_en) begin
            if (cnt == LAST_BYTE) state <= XS_HOLD;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= XS_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/spr_attr_dbuf.sv
module spr_attr_dbuf
  import spr_attr_pkg::*;
#(
  parameter int REC_CNT   = 128,
  parameter int DATA_W    = 8,
  parameter int H_W       = 10,
  parameter int V_W       = 10,
  parameter int XFER_LINE = 480,
  parameter int IDX_W     = $clog2(REC_CNT),
  parameter int ADDR_W    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic [H_W-1:0]    hcount,
  input  logic [V_W-1:0]    vcount,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              xfer_busy,
  input  logic [IDX_W-1:0]  rec_idx,
  output logic [DATA_W-1:0] rec_vpos,
  output logic [DATA_W-1:0] rec_code,
  output logic [DATA_W-1:0] rec_hpos
);
  logic              in_win;
  logic              copying;
  logic              xfer_rd_en;
  logic [ADDR_W-1:0] xfer_rd_addr;
  logic              xfer_wr_en;
  logic [ADDR_W-1:0] xfer_wr_addr;
  logic [DATA_W-1:0] stage_a_q;
  logic [DATA_W-1:0] stage_b_q;
  logic              blocked_q;
  logic [USED_LANES-1:0][DATA_W-1:0] rec_q;

  spr_xfer_ctrl #(
    .ADDR_W(ADDR_W), .H_W(H_W), .V_W(V_W), .XFER_LINE(XFER_LINE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hcount(hcount), .vcount(vcount),
    .in_win(in_win), .busy(xfer_busy), .copying(copying),
    .rd_en(xfer_rd_en), .rd_addr(xfer_rd_addr),
    .wr_en(xfer_wr_en), .wr_addr(xfer_wr_addr)
  );

  spr_stage_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk(clk),
    .a_we(cpu_we && !in_win), .a_re(cpu_re),
    .a_addr(cpu_addr), .a_wdata(cpu_wdata), .a_rdata(stage_a_q),
    .b_addr(xfer_rd_addr), .b_rdata(stage_b_q)
  );

  spr_active_ram #(.IDX_W(IDX_W), .DATA_W(DATA_W), .LANES(USED_LANES)) u_active (
    .clk(clk), .we(xfer_wr_en), .waddr(xfer_wr_addr), .wdata(stage_b_q),
    .rd_idx(rec_idx), .rd_rec(rec_q)
  );

  // A read taken during the window returns all ones
  always_ff @(posedge clk) begin
    if (rst)         blocked_q <= 1'b0;
    else if (cpu_re) blocked_q <= in_win;
  end

  assign cpu_rdata = blocked_q ? '1 : stage_a_q;
  assign rec_vpos  = rec_q[OFS_VPOS];
  assign rec_code  = rec_q[OFS_CODE];
  assign rec_hpos  = rec_q[OFS_HPOS];
endmodule

// File: rtl/spr_attr_dbuf_chk.sv
module spr_attr_dbuf_chk #(
  parameter int DATA_W    = 8,
  parameter int H_W       = 10,
  parameter int V_W       = 10,
  parameter int XFER_LINE = 480,
  parameter int ADDR_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              pix_en,
  input logic [H_W-1:0]    hcount,
  input logic [V_W-1:0]    vcount,
  input logic              cpu_re,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              xfer_busy,
  input logic              copying,
  input logic [ADDR_W-1:0] xfer_rd_addr
);
  logic win;
  assign win = (vcount == V_W'(XFER_LINE)) || (vcount == V_W'(XFER_LINE + 1));

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |-> $past(win));

  assert_blocked_read_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_re) && $past(win) && !$past(rst)) |-> (cpu_rdata == '1));

  assert_copy_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(copying) |-> ($past(hcount) == '0) && $past(win));

  assert_copy_step_R6: assert property (@(posedge clk) disable iff (rst)
    (copying && $past(copying) && $past(pix_en)) |->
      (xfer_rd_addr == ADDR_W'($past(xfer_rd_addr) + 1'b1)));

  assert_copy_busy_R6: assert property (@(posedge clk) disable iff (rst)
    copying |-> xfer_busy);

  assert_reset_abort_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && win) |=> !copying);
endmodule

bind spr_attr_dbuf spr_attr_dbuf_chk #(
  .DATA_W(DATA_W), .H_W(H_W), .V_W(V_W), .XFER_LINE(XFER_LINE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hcount(hcount), .vcount(vcount),
  .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .xfer_busy(xfer_busy),
  .copying(copying), .xfer_rd_addr(xfer_rd_addr)
);

// File: tb/spr_attr_dbuf_test.sv
module spr_attr_dbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int REC_CNT = 8, H_W = 5, V_W = 4, XFER_LINE = 7;
  localparam int H_TOT = 24, V_TOT = 10;
  localparam int NBYTES = REC_CNT * 4;
  localparam int IDX_W = $clog2(REC_CNT), ADDR_W = IDX_W + 2;

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0;
  logic [H_W-1:0] hcount = '0;
  logic [V_W-1:0] vcount = '0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_we = 1'b0, cpu_re = 1'b0, xfer_busy;
  logic [IDX_W-1:0] rec_idx = '0;
  logic [7:0] rec_vpos, rec_code, rec_hpos;

  spr_attr_dbuf #(.REC_CNT(REC_CNT), .DATA_W(8), .H_W(H_W), .V_W(V_W), .XFER_LINE(XFER_LINE)) uut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hcount(hcount), .vcount(vcount),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_rdata(cpu_rdata), .xfer_busy(xfer_busy), .rec_idx(rec_idx),
    .rec_vpos(rec_vpos), .rec_code(rec_code), .rec_hpos(rec_hpos)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] stage_m [NBYTES];
  logic [7:0] act_m [NBYTES];
  int cur_h = 0, cur_v = 0, kcnt = 0;
  bit armed = 0, copying = 0, prev_win = 0;
  bit op_we = 0, op_re = 0, op_rec = 0, op_rst = 1;
  logic [ADDR_W-1:0] op_addr = '0;
  logic [7:0] op_wd = '0;
  logic [IDX_W-1:0] op_idx = '0;
  logic [7:0] last_rd = '0;

  function automatic bit win_f(int v);
    return (v == XFER_LINE) || (v == XFER_LINE + 1);
  endfunction

  function automatic logic [7:0] pat(int a, int s);
    return 8'((a * 7 + 3 + s * 45) & 255);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (line %0d h %0d)", tag, act, exp, cur_v, cur_h);
    end
  endtask

  task automatic step();
    bit pix = ($urandom % 4) != 0;
    bit w = win_f(cur_v);
    bit do_rd = op_re && !op_rst;
    bit do_rec = op_rec && !w && !prev_win && !op_rst;
    logic [7:0] exp_rd = '0;
    logic [7:0] e_v, e_c, e_h;
    rst = op_rst; pix_en = pix;
    hcount = H_W'(cur_h); vcount = V_W'(cur_v);
    cpu_we = op_we; cpu_re = op_re; cpu_addr = op_addr; cpu_wdata = op_wd; rec_idx = op_idx;
    if (do_rd) exp_rd = w ? 8'hFF : stage_m[op_addr];
    e_v = act_m[{op_idx, 2'd0}];
    e_c = act_m[{op_idx, 2'd1}];
    e_h = act_m[{op_idx, 2'd2}];
    if (op_rst) begin
      copying = 0; armed = 0;
    end else begin
      if (copying) begin
        if (!w) copying = 0;
        else if (pix) begin
          act_m[kcnt] = stage_m[kcnt];
          kcnt++;
          if (kcnt == NBYTES) copying = 0;
        end
      end else if (armed) begin
        if (w && cur_h == 0) begin copying = 1; kcnt = 0; armed = 0; end
      end else if (!w) armed = 1;
      if (op_we && !w) stage_m[op_addr] = op_wd;
    end
    @(posedge clk); @(negedge clk);
    if (op_rst) chk("R9 busy in reset", {31'd0, xfer_busy}, 0);
    else        chk("R3 busy flag", {31'd0, xfer_busy}, {31'd0, w});
    if (do_rd) begin
      last_rd = cpu_rdata;
      chk(w ? "R5 blocked read" : "R1 staging read", {24'd0, cpu_rdata}, {24'd0, exp_rd});
    end
    if (do_rec) begin
      chk("R2 vpos lane", {24'd0, rec_vpos}, {24'd0, e_v});
      chk("R2 code lane", {24'd0, rec_code}, {24'd0, e_c});
      chk("R2 hpos lane", {24'd0, rec_hpos}, {24'd0, e_h});
    end
    prev_win = w;
    if (pix) begin
      cur_h++;
      if (cur_h == H_TOT) begin cur_h = 0; cur_v = (cur_v + 1) % V_TOT; end
    end
    op_we = 0; op_re = 0; op_rec = 0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    op_we = 1; op_addr = ADDR_W'(a); op_wd = d; step();
  endtask

  task automatic rd(int a);
    op_re = 1; op_addr = ADDR_W'(a); step();
  endtask

  task automatic rrec(int i);
    op_rec = 1; op_idx = IDX_W'(i); step();
  endtask

  task automatic run_to(int v);
    while (cur_v != v) step();
  endtask

  task automatic pass_window();
    run_to(XFER_LINE);
    run_to(XFER_LINE + 2);
    step();
  endtask

  initial begin
    int k;
    void'($urandom(32'd20240611));
    repeat (3) step();
    op_rst = 0;
    step();
    chk("R9 busy after reset", {31'd0, xfer_busy}, 0);

    // Fill staging before the first window and read it back
    for (int a = 0; a < NBYTES; a++) wr(a, pat(a, 0));
    for (int a = 0; a < NBYTES; a++) rd(a);

    // Window: write ignored, read blocked
    run_to(XFER_LINE);
    wr(3, 8'hAA);
    rd(3);
    chk("R5 read in window", {24'd0, last_rd}, 32'hFF);
    run_to(XFER_LINE + 2);
    step();
    rd(3);
    chk("R4 write in window dropped", {24'd0, last_rd}, {24'd0, pat(3, 0)});

    // Whole table copied with the byte layout per record
    for (int i = 0; i < REC_CNT; i++) begin
      rrec(i);
      chk("R6 vpos copied", {24'd0, rec_vpos}, {24'd0, pat(4 * i, 0)});
      chk("R6 code copied", {24'd0, rec_code}, {24'd0, pat(4 * i + 1, 0)});
      chk("R6 hpos copied", {24'd0, rec_hpos}, {24'd0, pat(4 * i + 2, 0)});
    end

    // Staging writes stay invisible until the next window
    wr(0, 8'h5A);
    rrec(0);
    chk("R7 active unchanged", {24'd0, rec_vpos}, {24'd0, pat(0, 0)});
    pass_window();
    rrec(0);
    chk("R6 new value after window", {24'd0, rec_vpos}, 32'h5A);

    // Reset in the middle of a copy
    for (int a = 0; a < NBYTES; a++) wr(a, pat(a, 1));
    run_to(XFER_LINE);
    while (!(copying && kcnt >= 10)) step();
    k = kcnt;
    op_rst = 1; step(); step(); op_rst = 0;
    run_to(XFER_LINE + 2);
    step();
    for (int i = 0; i < REC_CNT; i++) begin
      rrec(i);
      chk("R8 partial vpos", {24'd0, rec_vpos}, {24'd0, (4 * i < k) ? pat(4 * i, 1) : pat(4 * i, 0)});
      chk("R8 partial hpos", {24'd0, rec_hpos}, {24'd0, (4 * i + 2 < k) ? pat(4 * i + 2, 1) : pat(4 * i + 2, 0)});
    end
    pass_window();
    for (int i = 0; i < REC_CNT; i++) begin
      rrec(i);
      chk("R8 full copy next frame", {24'd0, rec_code}, {24'd0, pat(4 * i + 1, 1)});
    end

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      if (r < 3) begin op_we = 1; op_addr = ADDR_W'($urandom); op_wd = 8'($urandom); end
      else if (r < 6) begin op_re = 1; op_addr = ADDR_W'($urandom); end
      op_rec = 1; op_idx = IDX_W'($urandom);
      step();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule